// File: doc/BRIEF.md
# Bit-Sliced Four-Function ALU

This block is a purely combinational arithmetic logic unit of parameterised width (eight bits by default). It is built as a ripple chain of identical one-bit slices. Each slice holds a full adder, a multiplexer that passes the B bit either straight or inverted, and two cascaded two-way multiplexers. Those multiplexers pick the slice result from the AND term, the OR term and the adder sum. The carry-out of each slice feeds the carry-in of the slice above it.

A two-bit function code chooses among bitwise AND, bitwise OR, addition and subtraction. A small decoder turns the code into a struct of control strobes for the slice chain. The low code bit does two jobs: it selects inversion of B in every slice, and it is the carry into the lowest slice. Subtraction is therefore A plus the complement of B plus one. The high code bit gates the final carry, so the carry output is only non-zero for the two arithmetic codes. The unit has no clock and no reset. Result and carry settle from the operands and the code alone.

Top module: `slice_alu`

## Requirements
- R1: Function code 2'b00 gives Z = A & B, bit by bit.
- R2: Function code 2'b01 gives Z = A | B, bit by bit.
- R3: Function code 2'b10 gives Z = (A + B) mod 2^W, and carryOut equals bit W of the full sum A + B.
- R4: Function code 2'b11 gives Z = (A - B) mod 2^W, formed as A + ~B + 1.
- R5: While the high function bit is 0 (codes 2'b00 and 2'b01), carryOut is 0 for every pair of operands.
- R6: Under code 2'b11, carryOut is 1 when A >= B (unsigned, no borrow) and 0 when A < B. It does not give the sign of the result.
- R7: A carry entering the lowest slice can ripple through every slice up to carryOut. For example, A = all ones plus B = 1 gives Z = 0 with carryOut = 1, and 0 minus 1 gives Z = all ones with carryOut = 0.
- R8: For every input, {carryOut, Z} equals a word-wide reference: A + B for code 2'b10, A + ~B + 1 for code 2'b11, and {0, logic result} for the two logic codes.
- R9: The block is purely combinational. Outputs follow any change of A, B or the function code with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | W (8) | First operand |
| opB | input | W (8) | Second operand |
| funcSel | input | 2 | Function code: 00 AND, 01 OR, 10 ADD, 11 SUB |
| result | output | W (8) | Selected function result Z |
| carryOut | output | 1 | Final ripple carry, forced to 0 for logic codes |

## Verification
The bench drives AND and OR with B set to all ones and to all zeros while the carry chain is full of ones. A design that fails to gate the final carry would then show carryOut = 1 on a logic code. A full-length ripple case (all ones plus one, and zero minus one) shows the fault if the carry into the lowest slice is not driven by the low code bit, or if a link in the chain is broken. In that case Z comes out with stray ones and the carry is wrong. Subtraction cases with A below, equal to and above B separate a correct no-borrow carry from an inverted one. Random operands on all four codes catch a swapped select or a wrong multiplexer cascade.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

  typedef enum logic [1:0] {
    FN_AND = 2'b00,
    FN_OR  = 2'b01,
    FN_ADD = 2'b10,
    FN_SUB = 2'b11
  } funcSel_e;

  // Strobes from the decoder to the slice chain
  typedef struct packed {
    logic invertB;    // per-slice B inversion select
    logic carryIn;    // carry into slice 0
    logic keepCarry;  // pass the final carry to the port
    logic pickArith;  // second mux: adder sum over logic term
    logic pickOr;     // first mux: OR term over AND term
  } aluStrobes_t;

endpackage

// File: rtl/slice_alu_ctrl.sv
module slice_alu_ctrl
  import slice_alu_pkg::*;
(
  input  logic [1:0]  funcSel,
  output aluStrobes_t strobes
);

  funcSel_e fn;
  assign fn = funcSel_e'(funcSel);

  always_comb begin
    strobes = '0;
    unique case (fn)
      FN_AND: begin
        strobes.pickOr = 1'b0;
      end
      FN_OR: begin
        strobes.pickOr  = 1'b1;
        strobes.invertB = 1'b1;
        strobes.carryIn = 1'b1;
      end
      FN_ADD: begin
        strobes.pickArith = 1'b1;
        strobes.keepCarry = 1'b1;
      end
      FN_SUB: begin
        strobes.pickArith = 1'b1;
        strobes.keepCarry = 1'b1;
        strobes.invertB   = 1'b1;
        strobes.carryIn   = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

  // The low code bit feeds both inversion and slice-0 carry; the high bit gates the carry
  always_comb begin
    AST_CARRY_TRACKS_INVERT: assert (strobes.invertB == strobes.carryIn)
      else $error("carry-in and B inversion disagree"); // R4
    AST_GATE_ONLY_ARITH: assert (strobes.keepCarry == strobes.pickArith)
      else $error("carry gate out of step with arithmetic select"); // R5
  end

endmodule

// File: rtl/slice_alu_bit.sv
module slice_alu_bit (
  input  logic a,
  input  logic b,
  input  logic invertB,
  input  logic pickOr,
  input  logic pickArith,
  input  logic cin,
  output logic z,
  output logic cout
);

  logic bSel;
  logic sum;
  logic andTerm;
  logic orTerm;
  logic logicPick;

  // 2:1 mux choosing B or its complement
  assign bSel = invertB ? ~b : b;

  // full adder
  assign sum  = a ^ bSel ^ cin;
  assign cout = (a & bSel) | (cin & (a ^ bSel));

  assign andTerm = a & b;
  assign orTerm  = a | b;

  // cascaded 2:1 muxes acting as a 3:1 selector
  assign logicPick = pickOr ? orTerm : andTerm;
  assign z         = pickArith ? sum : logicPick;

endmodule

// File: rtl/slice_alu_datapath.sv
module slice_alu_datapath
  import slice_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluStrobes_t  strobes,
  output logic [W-1:0] result,
  output logic         carryOut
);

  logic [W:0] chain;

  assign chain[0] = strobes.carryIn;

  for (genvar i = 0; i < W; i++) begin : g_slice
    slice_alu_bit u_bit (
      .a        (opA[i]),
      .b        (opB[i]),
      .invertB  (strobes.invertB),
      .pickOr   (strobes.pickOr),
      .pickArith(strobes.pickArith),
      .cin      (chain[i]),
      .z        (result[i]),
      .cout     (chain[i+1])
    );
  end

  assign carryOut = chain[W] & strobes.keepCarry;

  // Word-wide reference check of the rippled arithmetic
  logic [W:0] wideAdd;
  logic [W:0] wideSub;
  assign wideAdd = {1'b0, opA} + {1'b0, opB};
  assign wideSub = {1'b0, opA} + {1'b0, ~opB} + {{W{1'b0}}, 1'b1};

  always_comb begin
    if (strobes.pickArith && !strobes.invertB && !strobes.carryIn) begin
      AST_RIPPLE_MATCHES_ADD: assert ({chain[W], result} == wideAdd)
        else $error("ripple sum differs from word add"); // R8
    end
    if (strobes.pickArith && strobes.invertB && strobes.carryIn) begin
      AST_RIPPLE_MATCHES_SUB: assert ({chain[W], result} == wideSub)
        else $error("ripple difference differs from word subtract"); // R8
    end
  end

endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [1:0]   funcSel,
  output logic [W-1:0] result,
  output logic         carryOut
);

  aluStrobes_t strobes;

  slice_alu_ctrl u_ctrl (
    .funcSel(funcSel),
    .strobes(strobes)
  );

  slice_alu_datapath #(.W(W)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .carryOut(carryOut)
  );

  always_comb begin
    if (funcSel == 2'b00) begin
      AST_AND_RESULT: assert (result == (opA & opB))
        else $error("AND result wrong"); // R1
    end
    if (funcSel == 2'b01) begin
      AST_OR_RESULT: assert (result == (opA | opB))
        else $error("OR result wrong"); // R2
    end
    if (!funcSel[1]) begin
      AST_LOGIC_NO_CARRY: assert (carryOut == 1'b0)
        else $error("carry leaked on logic code"); // R5
    end
    if (funcSel == 2'b11) begin
      AST_SUB_NO_BORROW: assert (carryOut == (opA >= opB))
        else $error("subtract carry not the no-borrow flag"); // R6
    end
  end

endmodule

// File: tb/slice_alu_tb.sv
module slice_alu_tb;

  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [W-1:0] opA, opB, result;
  logic [1:0]   funcSel;
  logic         carryOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  slice_alu #(.W(W)) u_dut (
    .opA(opA), .opB(opB), .funcSel(funcSel),
    .result(result), .carryOut(carryOut)
  );

  function automatic logic [W:0] refModel(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] f);
    logic [W:0] r;
    case (f)
      2'b00: r = {1'b0, a & b};
      2'b01: r = {1'b0, a | b};
      2'b10: r = {1'b0, a} + {1'b0, b};
      default: r = {1'b0, a} + {1'b0, ~b} + 1;
    endcase
    return r;
  endfunction

  task automatic checkOut(string req, logic [W-1:0] expZ, logic expC);
    checks++;
    if (result !== expZ || carryOut !== expC) begin
      errors++;
      $display("FAIL %s: A=%h B=%h F=%b got Z=%h C=%b expected Z=%h C=%b",
               req, opA, opB, funcSel, result, carryOut, expZ, expC);
    end
  endtask

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] f);
    @(negedge clk);
    opA = a; opB = b; funcSel = f;
    #1;
  endtask

  task automatic testInitial();
    // R9: outputs settle with no clock edge needed
    opA = 8'h0F; opB = 8'h33; funcSel = 2'b00;
    #1;
    checkOut("R9", 8'h03, 1'b0);
  endtask

  task automatic testAnd();
    apply(8'hA5, 8'hFF, 2'b00); checkOut("R1", 8'hA5, 1'b0);
    apply(8'hA5, 8'h00, 2'b00); checkOut("R1", 8'h00, 1'b0);
    apply(8'hFF, 8'hFF, 2'b00); checkOut("R5", 8'hFF, 1'b0);
  endtask

  task automatic testOr();
    apply(8'h3C, 8'hFF, 2'b01); checkOut("R2", 8'hFF, 1'b0);
    apply(8'h3C, 8'h00, 2'b01); checkOut("R2", 8'h3C, 1'b0);
    apply(8'hFF, 8'h00, 2'b01); checkOut("R5", 8'hFF, 1'b0);
  endtask

  task automatic testAdd();
    apply(8'hEB, 8'hFF, 2'b10); checkOut("R3", 8'hEA, 1'b1);
    apply(8'hCD, 8'hFF, 2'b10); checkOut("R3", 8'hCC, 1'b1);
    apply(8'h5A, 8'h00, 2'b10); checkOut("R3", 8'h5A, 1'b0);
    apply(8'hFF, 8'h01, 2'b10); checkOut("R7", 8'h00, 1'b1);
  endtask

  task automatic testSub();
    apply(8'h3F, 8'hFF, 2'b11); checkOut("R4", 8'h40, 1'b0);
    apply(8'h2E, 8'hFF, 2'b11); checkOut("R4", 8'h2F, 1'b0);
    apply(8'h77, 8'h00, 2'b11); checkOut("R6", 8'h77, 1'b1);
    apply(8'h40, 8'h40, 2'b11); checkOut("R6", 8'h00, 1'b1);
    apply(8'h10, 8'h20, 2'b11); checkOut("R6", 8'hF0, 1'b0);
    apply(8'h00, 8'h01, 2'b11); checkOut("R7", 8'hFF, 1'b0);
  endtask

  task automatic testChange();
    // R9: switching only the code changes outputs at once
    apply(8'hFF, 8'h01, 2'b10);
    funcSel = 2'b11; #1;
    checkOut("R9", 8'hFE, 1'b1);
  endtask

  task automatic testRandom();
    for (int i = 0; i < 400; i++) begin
      logic [W:0] exp;
      logic [W-1:0] a, b;
      logic [1:0] f;
      a = W'($urandom); b = W'($urandom); f = 2'(i);
      apply(a, b, f);
      exp = refModel(a, b, f);
      checkOut("R8", exp[W-1:0], exp[W]);
    end
  endtask

  initial begin
    testInitial();
    testAnd();
    testOr();
    testAdd();
    testSub();
    testChange();
    testRandom();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule